// File: doc/BRIEF.md
# Transfer Attribute Capture Decoder

This block sits on the processor side of a cache controller. It takes a snapshot of the processor's transfer attributes on the clock edge where an address phase begins. The attributes it samples are direction, burst, size, cache-inhibit, write-through, transfer code, global and the two user page bits. From that snapshot it builds a registered transaction descriptor for the downstream logic. The descriptor gives the access class, a supervisor flag, the number of double-word beats, the byte lanes of a 64-bit data bus that are used, and whether the access may be cached.

During an atomic read-write pair, the processor holds its lock line high across both transfers and across the gap between them. While that is true, the block keeps the descriptor from the read half fixed, and only the direction flag follows the write half. The lock line is passed straight through to the system side. The user page bits are forwarded with the descriptor, except that copyback transfers carry zeros. A reserved transfer code, or a single-beat address that is not aligned to its size, sets an error flag that stays set until reset and suppresses the descriptor valid bit.

Top module: `xfer_attr_decoder`

## Requirements
- R1: All descriptor outputs are registered. They take the values of a capture on the clock edge where `start_i` is high, and they hold those values until the next capture. After reset, every output is 0 except `sys_lock_o`.
- R2: For a single-beat transfer, size code 00 is 8 bytes, 01 is 4 bytes, 10 is 2 bytes and 11 is 1 byte. Bit i of `byte_en_o` is the lane of byte offset i, and the enabled lanes are ((1<<bytes)-1) << `addr_lo_i`.
- R3: A single-beat transfer whose `addr_lo_i` is not a multiple of its byte count sets `err_o`, leaves `desc_valid_o` low and drives `byte_en_o` to 0.
- R4: With `burst_i` high and `ci_i` low, `beats_o` is 4 and `byte_en_o` is 8'hFF, whatever the size code and address. A single-beat transfer gives `beats_o` = 1.
- R5: With `ci_i` high, `burst_i` is ignored: the transfer is single-beat, size and alignment apply, and `cacheable_o` is 0. `cacheable_o` is 1 when `ci_i` is low.
- R6: `class_o` decodes the transfer code as follows:
  - data (0): 0001 and 0101
  - touch/flush/allocate (1): 0010 and 0110
  - table search (2): 0011 and 1011
  - copyback (3): 0100 and 0111
  - instruction (4): 1001 and 1101

  `super_o` is 1 only for 0101, 0110 and 1101.
- R7: Any other transfer code is reserved. It sets `err_o` and leaves `desc_valid_o` low.
- R8: `sys_lock_o` equals `lock_i` in the same cycle.
- R9: A capture made with `lock_i` high opens a locked sequence, which lasts while `lock_i` stays high. During it, further captures change only `is_read_o`, and every other descriptor output holds. When `lock_i` is low at a clock edge, the sequence ends.
- R10: `sys_upa_o` is the captured `upa_i`, forced to 00 when the captured class is copyback.
- R11: `is_read_o`, `wt_o` and `global_o` carry the captured `rw_i`, `wt_i` and `gbl_i`.
- R12: Once set, `err_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Address phase begins; capture attributes |
| rw_i | input | 1 | 1 = read, 0 = write |
| burst_i | input | 1 | Burst request |
| size_i | input | 2 | Transfer size code |
| addr_lo_i | input | 3 | Low address bits |
| ci_i | input | 1 | Cache-inhibit |
| wt_i | input | 1 | Write-through |
| tc_i | input | 4 | Transfer code |
| gbl_i | input | 1 | Global (snoop) marking |
| upa_i | input | 2 | User page attribute bits |
| lock_i | input | 1 | Atomic sequence lock |
| desc_valid_o | output | 1 | Descriptor valid |
| is_read_o | output | 1 | Captured direction |
| class_o | output | 3 | Access class |
| super_o | output | 1 | Supervisor access |
| beats_o | output | 3 | Double-word beats |
| byte_en_o | output | 8 | Byte lane enables |
| cacheable_o | output | 1 | Access may be cached |
| wt_o | output | 1 | Captured write-through |
| global_o | output | 1 | Captured global |
| sys_upa_o | output | 2 | User page bits toward the system side |
| sys_lock_o | output | 1 | Lock toward the system side |
| err_o | output | 1 | Sticky attribute error |

## Verification
Every descriptor output and the error flag change at the first rising edge after `start_i` is driven high. The bench drives `start_i` on a falling edge, releases it on the next falling edge, and checks the outputs there, half a cycle after the capturing edge. The system lock output has no register on its path, so it is checked a few nanoseconds after `lock_i` changes, with no clock edge in between. Each sweep case starts from reset, so the sticky flag of one case cannot hide the result of the next. The locked-sequence checks run several idle cycles and a second capture before they sample.

// File: rtl/xfer_attr_decoder.sv
module xfer_attr_decoder #(
  parameter int LANES       = 8,
  parameter int BURST_BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     rw_i,
  input  logic                     burst_i,
  input  logic [1:0]               size_i,
  input  logic [$clog2(LANES)-1:0] addr_lo_i,
  input  logic                     ci_i,
  input  logic                     wt_i,
  input  logic [3:0]               tc_i,
  input  logic                     gbl_i,
  input  logic [1:0]               upa_i,
  input  logic                     lock_i,
  output logic                     desc_valid_o,
  output logic                     is_read_o,
  output logic [2:0]               class_o,
  output logic                     super_o,
  output logic [$clog2(BURST_BEATS+1)-1:0] beats_o,
  output logic [LANES-1:0]         byte_en_o,
  output logic                     cacheable_o,
  output logic                     wt_o,
  output logic                     global_o,
  output logic [1:0]               sys_upa_o,
  output logic                     sys_lock_o,
  output logic                     err_o
);
  localparam int AW = $clog2(LANES);
  localparam int BW = $clog2(BURST_BEATS + 1);
  localparam logic [2:0] C_DATA = 3'd0, C_TOUCH = 3'd1, C_TABLE = 3'd2,
                         C_COPYBACK = 3'd3, C_INSTR = 3'd4;

  logic [2:0] cls;
  logic       sup, code_ok;

  always_comb begin
    cls = C_DATA;
    sup = 1'b0;
    code_ok = 1'b1;
    case (tc_i)
      4'b0001: cls = C_DATA;
      4'b0101: begin cls = C_DATA; sup = 1'b1; end
      4'b0010: cls = C_TOUCH;
      4'b0110: begin cls = C_TOUCH; sup = 1'b1; end
      4'b0011, 4'b1011: cls = C_TABLE;
      4'b0100, 4'b0111: cls = C_COPYBACK;
      4'b1001: cls = C_INSTR;
      4'b1101: begin cls = C_INSTR; sup = 1'b1; end
      default: code_ok = 1'b0;
    endcase
  end

  logic              eff_burst, aligned, misaligned, lock_hold, held;
  logic [AW:0]       nbytes;
  logic [AW-1:0]     amask;
  logic [LANES-1:0]  lmask, lanes;

  assign eff_burst  = burst_i & ~ci_i;
  assign nbytes     = (AW+1)'(LANES) >> size_i;
  assign amask      = AW'(nbytes - 1'b1);
  assign aligned    = (addr_lo_i & amask) == '0;
  assign lmask      = {LANES{1'b1}} >> (LANES - int'(nbytes));
  assign misaligned = ~eff_burst & ~aligned;
  assign lanes      = eff_burst ? {LANES{1'b1}} : (misaligned ? '0 : lmask << addr_lo_i);
  assign held       = lock_hold & lock_i;
  assign sys_lock_o = lock_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_valid_o <= 1'b0;
      is_read_o    <= 1'b0;
      class_o      <= '0;
      super_o      <= 1'b0;
      beats_o      <= '0;
      byte_en_o    <= '0;
      cacheable_o  <= 1'b0;
      wt_o         <= 1'b0;
      global_o     <= 1'b0;
      sys_upa_o    <= '0;
      err_o        <= 1'b0;
      lock_hold    <= 1'b0;
    end else begin
      lock_hold <= lock_i & (lock_hold | start_i);
      if (start_i) begin
        is_read_o <= rw_i;
        if (!held) begin
          desc_valid_o <= code_ok & ~misaligned;
          class_o      <= cls;
          super_o      <= sup;
          beats_o      <= eff_burst ? BW'(BURST_BEATS) : BW'(1);
          byte_en_o    <= lanes;
          cacheable_o  <= ~ci_i;
          wt_o         <= wt_i;
          global_o     <= gbl_i;
          sys_upa_o    <= (code_ok && cls == C_COPYBACK) ? 2'b00 : upa_i;
          if (!code_ok || misaligned) err_o <= 1'b1;
        end
      end
    end
  end

  assert_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o |-> (beats_o == BW'(1) || beats_o == BW'(BURST_BEATS)));
  assert_burst_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && beats_o == BW'(BURST_BEATS)) |-> byte_en_o == {LANES{1'b1}});
  assert_ci_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && !cacheable_o) |-> beats_o == BW'(1));
  assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid_o |-> ($countones(byte_en_o) inside {1, 2, 4, 8}));
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_upa_copyback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid_o && class_o == C_COPYBACK) |-> sys_upa_o == 2'b00);
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hold && lock_i) |=> ($stable(byte_en_o) && $stable(class_o) &&
                               $stable(beats_o) && $stable(desc_valid_o)));
  assert_invalid_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_valid_o && byte_en_o == '0 && beats_o == BW'(1)) |-> err_o);
endmodule

// File: tb/sim_xfer_attr_decoder.sv
`timescale 1ns/1ps
module sim_xfer_attr_decoder;
  logic clk = 0, rst_n = 0, start = 0, rw = 0, burst = 0, ci = 0, wt = 0, gbl = 0, lock = 0;
  logic [1:0] size = 0, upa = 0;
  logic [2:0] addr = 0;
  logic [3:0] tc = 0;
  logic dv, rd, sup, cach, wto, glo, slock, err;
  logic [2:0] cls, beats;
  logic [7:0] be;
  logic [1:0] supa;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_attr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rw_i(rw), .burst_i(burst),
    .size_i(size), .addr_lo_i(addr), .ci_i(ci), .wt_i(wt), .tc_i(tc),
    .gbl_i(gbl), .upa_i(upa), .lock_i(lock), .desc_valid_o(dv), .is_read_o(rd),
    .class_o(cls), .super_o(sup), .beats_o(beats), .byte_en_o(be),
    .cacheable_o(cach), .wt_o(wto), .global_o(glo), .sys_upa_o(supa),
    .sys_lock_o(slock), .err_o(err));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic capture();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  function automatic int exp_class(logic [3:0] c);
    case (c)
      4'b0001, 4'b0101: return 0;
      4'b0010, 4'b0110: return 1;
      4'b0011, 4'b1011: return 2;
      4'b0100, 4'b0111: return 3;
      4'b1001, 4'b1101: return 4;
      default: return -1;
    endcase
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset valid", dv, 0);
    chk("R1 reset lanes", be, 0);
    chk("R1 reset err", err, 0);
    chk("R1 reset beats", beats, 0);

    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 8; a++)
          for (int m = 0; m < 4; m++) begin
            int ec, nb, eb;
            bit res, eburst, mis;
            logic [7:0] elanes;
            do_reset();
            tc = 4'(c); size = 2'(s); addr = 3'(a);
            burst = m[0]; ci = m[1];
            rw = a[0]; wt = c[0] ^ s[0]; gbl = a[1]; upa = 2'(a + c);
            capture();
            ec = exp_class(tc);
            res = (ec < 0);
            eburst = burst && !ci;
            nb = 8 >> s;
            mis = !eburst && (a % nb != 0);
            elanes = eburst ? 8'hFF : (mis ? 8'h00 : 8'(((1 << nb) - 1) << a));
            eb = eburst ? 4 : 1;
            chk("R2 R3 R4 lanes", be, elanes);
            chk("R4 R5 beats", beats, eb);
            chk("R5 cacheable", cach, !ci);
            chk("R3 R7 valid", dv, !(res || mis));
            chk("R3 R7 R12 err", err, res || mis);
            chk("R11 fields", {rd, wto, glo}, {rw, wt, gbl});
            if (!res) begin
              chk("R6 class", cls, ec);
              chk("R6 super", sup, (tc == 4'b0101 || tc == 4'b0110 || tc == 4'b1101));
              chk("R10 upa", supa, (ec == 3) ? 2'b00 : upa);
            end
          end

    // R12: error persists across a later good capture
    do_reset();
    tc = 4'b0000; burst = 0; ci = 0; size = 0; addr = 0; capture();
    tc = 4'b0001; capture();
    chk("R12 sticky err", err, 1);
    chk("R12 valid after good", dv, 1);

    // R8: lock passes through with no clock
    do_reset();
    @(negedge clk); lock = 1; #1;
    chk("R8 lock high", slock, 1);
    lock = 0; #1;
    chk("R8 lock low", slock, 0);

    // R9: locked pair
    @(negedge clk);
    lock = 1; rw = 1; tc = 4'b0101; size = 2'b11; addr = 3; burst = 0; ci = 0; upa = 2'b10;
    capture();
    chk("R9 first lanes", be, 8'h08);
    tc = 4'b1001; size = 2'b00; addr = 0; burst = 1; upa = 2'b01; rw = 0;
    repeat (3) @(negedge clk);
    capture();
    chk("R9 held lanes", be, 8'h08);
    chk("R9 held class", cls, 0);
    chk("R9 held beats", beats, 1);
    chk("R9 held upa", supa, 2'b10);
    chk("R9 write half", rd, 0);
    @(negedge clk); lock = 0;
    @(negedge clk);
    capture();
    chk("R9 released lanes", be, 8'hFF);
    chk("R9 released class", cls, 4);
    chk("R9 released beats", beats, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule